// File: doc/BRIEF.md
# Big-Endian Byte and Word Load-Store Unit

This unit sits between a processor core and a memory that is 32 bits wide and organised in whole words. The core hands it one request per cycle: an operation (word load, word store, byte load or byte store), a byte address and the store data. One cycle later the unit presents a word-aligned request to the memory, with a write-enable mask for each byte. Read data comes back one cycle after a read request. The unit then produces the load result: the whole word for a word load, or the addressed byte sign-extended to 32 bits for a byte load.

Byte lanes are numbered in big-endian order. The lowest byte address inside a word selects the most significant byte. A byte store copies its byte into all four lanes of the write data, so the write-enable mask alone decides which byte changes. A word access whose address is not a multiple of four is rejected. It raises a misalignment flag for one cycle and reaches neither memory nor the load result.

Top module: `be_lsu`

## Requirements
- R1: When a request reaches memory, `mem_addr` equals the request's byte address with bits [1:0] forced to zero. It appears in the cycle after the request is accepted.
- R2: A byte store at offset k = address bits [1:0] drives `mem_be` one-hot with bit (3-k) set: offset 0 gives 4'b1000 and offset 3 gives 4'b0001. Bit 3 of `mem_be` governs data bits [31:24].
- R3: An aligned word store drives `mem_be` = 4'b1111, and `mem_wdata` equals the store data unchanged.
- R4: A byte store drives `mem_wdata` with store-data bits [7:0] repeated in all four bytes. Only the byte selected by R2 changes in memory.
- R5: A byte load at offset k returns memory bits [31-8k:24-8k] in `ld_data[7:0]`, with bit 7 of that byte copied into `ld_data[31:8]`.
- R6: An aligned word load returns the 32-bit memory word unchanged in `ld_data`.
- R7: A word load or word store whose address bits [1:0] are not zero raises `misalign` for one cycle, in the cycle where the memory request would have appeared. In that cycle `mem_req` is low and `mem_be` is zero, the addressed memory word is left unchanged, and no `ld_valid` follows. Byte accesses are never flagged.
- R8: `ld_valid` pulses for one cycle, exactly one cycle after the read request of an aligned load. It never follows a store.
- R9: While reset is asserted, `mem_req`, `mem_wr`, `mem_be`, `misalign` and `ld_valid` are all low.
- R10: In a cycle with no accepted request, the following cycle shows `mem_req` low, `mem_wr` low and `mem_be` zero.
- R11: Operation encoding on `req_op`: 2'b00 word load, 2'b01 word store, 2'b10 byte load, 2'b11 byte store. Bit 0 selects store and bit 1 selects byte size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation code (see R11) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data; byte stores use bits [7:0] |
| mem_req | output | 1 | Memory access this cycle |
| mem_wr | output | 1 | The access is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte write enables, bit 3 for bits [31:24] |
| mem_wdata | output | 32 | Memory write data |
| misalign | output | 1 | Rejected misaligned word access |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
If a lane index is stored wrongly in the first stage, a wrong `mem_be` appears in the very next cycle. A wrong byte lands in memory and shows up as a mismatch on the next word load of that address. If the offset or size held for the read return is corrupted, `ld_data` is wrong in the one cycle that `ld_valid` is high. If the rejection path fails, a stray `mem_req` or a missing `misalign` pulse shows in the cycle after the request. A failed rejection also shows later, as a word that was changed when it should not have been.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

   // bit 0: store, bit 1: byte size
   typedef enum logic [1:0] {
      LSU_WORD_LD = 2'b00,
      LSU_WORD_ST = 2'b01,
      LSU_BYTE_LD = 2'b10,
      LSU_BYTE_ST = 2'b11
   } lsu_op_e;

   localparam int unsigned LSU_BYTE_W = 8;

   function automatic logic op_is_store(input lsu_op_e op);
      return op[0];
   endfunction

   function automatic logic op_is_byte(input lsu_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
   parameter int unsigned OFF_W = 2
) (
   input  logic             valid,
   input  logic             is_byte,
   input  logic [OFF_W-1:0] offset,
   output logic             misaligned
);
   // a full-width access must start on a word boundary
   always_comb begin
      misaligned = valid && !is_byte && (offset != '0);
   end
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8,
   parameter int unsigned OFF_W  = $clog2(LANES)
) (
   input  logic              wr_en,
   input  logic              is_byte,
   input  logic [OFF_W-1:0]  offset,
   input  logic [DATA_W-1:0] src,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] data
);
   localparam int unsigned BW = be_lsu_pkg::LSU_BYTE_W;

   // lane i (byte offset i) sits in the i-th byte from the top
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int unsigned HI = DATA_W - 1 - BW * i;
      logic hit;
      assign hit                = (offset == OFF_W'(i));
      assign be[LANES-1-i]      = wr_en && (!is_byte || hit);
      assign data[HI -: BW]     = is_byte ? src[BW-1:0] : src[HI -: BW];
   end
endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LANES    = DATA_W / 8,
   parameter int unsigned OFF_W    = $clog2(LANES),
   parameter bit          SIGN_EXT = 1'b1
) (
   input  logic              is_byte,
   input  logic [OFF_W-1:0]  offset,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] result
);
   localparam int unsigned BW = be_lsu_pkg::LSU_BYTE_W;

   logic [BW-1:0]     lane_q [LANES];
   logic [BW-1:0]     picked;
   logic [DATA_W-1:0] widened;

   for (genvar i = 0; i < LANES; i++) begin : g_split
      assign lane_q[i] = rdata[DATA_W - 1 - BW * i -: BW];
   end

   assign picked = lane_q[offset];

   if (SIGN_EXT) begin : g_sext
      assign widened = {{(DATA_W-BW){picked[BW-1]}}, picked};
   end else begin : g_zext
      assign widened = {{(DATA_W-BW){1'b0}}, picked};
   end

   assign result = is_byte ? widened : rdata;
endmodule

// File: rtl/be_lsu.sv
module be_lsu #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter bit          SIGN_EXT = 1'b1
) (
   input  logic                 clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_op,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                mem_req,
   output logic                mem_wr,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic                misalign,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                ld_valid,
   output logic [DATA_W-1:0]   ld_data
);
   import be_lsu_pkg::*;

   localparam int unsigned LANES = DATA_W / LSU_BYTE_W;
   localparam int unsigned OFF_W = $clog2(LANES);

   if ((DATA_W % LSU_BYTE_W) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0)
   begin : g_bad_width
      $error("be_lsu: DATA_W must be a power-of-two count of bytes, at least two");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("be_lsu: ADDR_W too narrow for the byte offset");
   end

   // decode of the incoming request
   lsu_op_e             op;
   logic                is_st, is_byte, bad_align, go;
   logic [OFF_W-1:0]    off;
   logic [LANES-1:0]    be_nxt;
   logic [DATA_W-1:0]   wd_nxt;

   assign op      = lsu_op_e'(req_op);
   assign is_st   = op_is_store(op);
   assign is_byte = op_is_byte(op);
   assign off     = req_addr[OFF_W-1:0];
   assign go      = req_valid && !bad_align;

   lsu_align_chk #(.OFF_W(OFF_W)) u_align (
      .valid      (req_valid),
      .is_byte    (is_byte),
      .offset     (off),
      .misaligned (bad_align)
   );

   lsu_store_path #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_store (
      .wr_en   (go && is_st),
      .is_byte (is_byte),
      .offset  (off),
      .src     (req_wdata),
      .be      (be_nxt),
      .data    (wd_nxt)
   );

   // stage 1: memory request
   logic             s1_byte;
   logic [OFF_W-1:0] s1_off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_wr    <= 1'b0;
         mem_be    <= '0;
         misalign  <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         s1_byte   <= 1'b0;
         s1_off    <= '0;
      end else begin
         mem_req   <= go;
         mem_wr    <= go && is_st;
         mem_be    <= be_nxt;
         misalign  <= bad_align;
         mem_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
         mem_wdata <= wd_nxt;
         s1_byte   <= is_byte;
         s1_off    <= off;
      end
   end

   // stage 2: read return
   logic             s2_byte;
   logic [OFF_W-1:0] s2_off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_valid <= 1'b0;
         s2_byte  <= 1'b0;
         s2_off   <= '0;
      end else begin
         ld_valid <= mem_req && !mem_wr;
         s2_byte  <= s1_byte;
         s2_off   <= s1_off;
      end
   end

   lsu_load_path #(
      .DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W), .SIGN_EXT(SIGN_EXT)
   ) u_load (
      .is_byte (s2_byte),
      .offset  (s2_off),
      .rdata   (mem_rdata),
      .result  (ld_data)
   );
endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                mem_req,
   input logic                mem_wr,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_be,
   input logic                misalign,
   input logic                ld_valid
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned OFF_W = $clog2(LANES);

   AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R1

   AST_WRITE_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($countones(mem_be) == 1 || &mem_be)); // R2

   AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_req); // R3

   AST_REJECT_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_req && mem_be == '0)); // R7

   AST_LOAD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(mem_req && !mem_wr)); // R8

   AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> (!mem_req && !mem_wr && mem_be == '0)); // R10
endmodule

bind be_lsu be_lsu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .mem_req   (mem_req),
   .mem_wr    (mem_wr),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .misalign  (misalign),
   .ld_valid  (ld_valid)
);

// File: tb/be_lsu_test.sv
module be_lsu_test;
   localparam int CLK_PERIOD = 10;
   localparam int WORDS      = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_req, mem_wr, misalign, ld_valid;
   logic [31:0] mem_addr, mem_wdata, ld_data;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   be_lsu uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .mem_req(mem_req),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .misalign(misalign), .mem_rdata(mem_rdata),
      .ld_valid(ld_valid), .ld_data(ld_data)
   );

   function automatic logic [31:0] seed_word(input int i);
      return (32'h9E3779B9 * (i + 1)) ^ (32'h00800080 * (i & 1));
   endfunction

   // memory model driven by the unit's outputs
   logic [31:0] bmem [WORDS];
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_wr) begin
            for (int k = 0; k < 4; k++)
               if (mem_be[3-k]) bmem[mem_addr[5:2]][31-8*k -: 8] <= mem_wdata[31-8*k -: 8];
         end else begin
            mem_rdata <= bmem[mem_addr[5:2]];
         end
      end
   end

   // reference model, driven only by the request inputs
   logic [31:0] rmem [WORDS];
   logic        e_req, e_wr, e_mis;
   logic [31:0] e_addr, e_wdata;
   logic [3:0]  e_be;
   logic        lq_v [2];
   logic [31:0] lq_d [2];

   always @(posedge clk) begin
      if (!rst_n) begin
         e_req <= 0; e_wr <= 0; e_mis <= 0; e_be <= 0; e_addr <= 0; e_wdata <= 0;
         lq_v[0] <= 0; lq_v[1] <= 0; lq_d[0] <= 0; lq_d[1] <= 0;
      end else begin
         bit st, by, bad;
         int off, idx;
         logic [31:0] w;
         logic [7:0] b;
         st  = req_op[0];
         by  = req_op[1];
         off = int'(req_addr[1:0]);
         idx = int'(req_addr[5:2]);
         bad = req_valid && !by && off != 0;
         e_mis   <= bad;
         e_req   <= req_valid && !bad;
         e_wr    <= req_valid && !bad && st;
         e_addr  <= {req_addr[31:2], 2'b00};
         e_wdata <= by ? {4{req_wdata[7:0]}} : req_wdata;
         e_be    <= (req_valid && !bad && st) ? (by ? (4'b1000 >> off) : 4'hF) : 4'h0;
         w = rmem[idx];
         b = w[31-8*off -: 8];
         lq_v[1] <= lq_v[0];
         lq_d[1] <= lq_d[0];
         lq_v[0] <= req_valid && !bad && !st;
         lq_d[0] <= by ? {{24{b[7]}}, b} : w;
         if (req_valid && !bad && st) begin
            if (by) rmem[idx][31-8*off -: 8] = req_wdata[7:0];
            else    rmem[idx] = req_wdata;
         end
      end
   end

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
      end
   endtask

   // comparison away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         chk("R9", "reset outputs", {27'd0, mem_req, mem_wr, misalign, ld_valid, |mem_be}, 32'd0);
      end else if (!done) begin
         chk("R10", "mem_req", {31'd0, mem_req}, {31'd0, e_req});
         chk("R7", "misalign", {31'd0, misalign}, {31'd0, e_mis});
         chk("R2", "mem_be", {28'd0, mem_be}, {28'd0, e_be});
         chk("R8", "ld_valid", {31'd0, ld_valid}, {31'd0, lq_v[1]});
         if (e_req) chk("R1", "mem_addr", mem_addr, e_addr);
         if (e_wr) begin
            chk("R4", "mem_wr", {31'd0, mem_wr}, 32'd1);
            chk("R3", "mem_wdata", mem_wdata, e_wdata);
         end
         if (lq_v[1]) chk("R5", "ld_data", ld_data, lq_d[1]);
      end
   end

   task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         req_valid = 1'b0;
      end
   endtask

   initial begin
      logic [31:0] lf;
      for (int i = 0; i < WORDS; i++) begin
         bmem[i] = seed_word(i);
         rmem[i] = seed_word(i);
      end
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      idle(3);                                         // R10 idle
      // R11 encodings: 00 lw, 01 sw, 10 lb, 11 sb
      issue(2'b01, 32'd8, 32'hCAFE_F00D);              // R3 word store
      issue(2'b00, 32'd8, 32'h0);                      // R6 word load
      issue(2'b11, 32'd12, 32'h0000_0011);             // R2 offset 0
      issue(2'b11, 32'd13, 32'hFFFF_FF82);             // R4 offset 1
      issue(2'b11, 32'd14, 32'h1234_5633);             // offset 2
      issue(2'b11, 32'd15, 32'h0000_00C4);             // offset 3
      issue(2'b00, 32'd12, 32'h0);                     // R6 assembled word
      for (int k = 0; k < 4; k++) issue(2'b10, 32'd12 + k, 32'h0); // R5 sign
      for (int k = 0; k < 4; k++) issue(2'b10, 32'd20 + k, 32'h0);
      issue(2'b00, 32'd5, 32'h0);                      // R7 misaligned load
      issue(2'b01, 32'd6, 32'hDEAD_BEEF);              // R7 misaligned store
      issue(2'b01, 32'd7, 32'hDEAD_BEEF);
      issue(2'b00, 32'd4, 32'h0);                      // R7 word untouched
      issue(2'b10, 32'd7, 32'h0);                      // byte never flagged
      issue(2'b01, 32'd16, 32'h7F00_0080);             // store then load
      issue(2'b00, 32'd16, 32'h0);
      issue(2'b10, 32'd19, 32'h0);
      idle(2);
      lf = 32'h1357_9BDF;
      for (int n = 0; n < 400; n++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         if (lf[31:29] == 3'b000) idle(1);
         else issue(lf[1:0], {26'd0, lf[9:4]}, lf ^ 32'hA5A5_5A5A);
      end
      idle(2);
      for (int i = 0; i < WORDS; i++) issue(2'b00, 32'(4 * i), 32'h0); // final sweep R6
      idle(4);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule